// File: doc/BRIEF.md
# PCI configuration port translator

This block sits on a host I/O port bus. It turns the legacy address/data port pair into configuration requests. A software-visible selector register sits at the address port (I/O byte address CF8h). It holds an enable bit and a packed bus, device, function and dword-offset selection. When the enable bit is set, any access to the data window (CFCh through CFFh) becomes a single configuration request on a downstream request/completion interface. That request carries the selection, the byte enables and the write data. When the enable bit is clear, the data window is just another I/O location. Any access the block does not consume itself is passed unchanged to a generic I/O forwarding interface.

The host bus is dword-addressed and uses byte enables. Data sits on its native byte lanes, so byte, word and dword accesses to the data window map directly onto the byte enables of the selected configuration dword. Only one access is in flight at a time. The host sees `hst_rdy` low from the cycle after acceptance until the single-cycle response pulse has been given.

Top module: `cfg_port_xlat`

## Requirements
- R1: After reset the selector register is zero, so configuration is disabled. `hst_rdy` is high, no downstream request is raised, and a dword read of the address port returns 0.
- R2: A write to the address port with all four byte enables set stores the enable (bit 31), bus (bits 23:16), device (bits 15:11), function (bits 10:8) and dword offset (bits 7:2). A full-dword read of the address port returns that value with bits 30:24 and 1:0 forced to zero.
- R3: With the enable stored as 1, an access to the data-window dword raises `cfg_req_vld` and not `io_req_vld`. The request carries the stored bus, device, function and dword offset, together with the host write flag, byte enables and write data.
- R4: The host byte enables of a data-window access are passed through as `cfg_be`. In every response, byte lanes whose enable was 0 read as zero, and enabled lanes carry the returned data.
- R5: With the enable stored as 0, a data-window access is forwarded on the I/O interface with its dword address, byte enables, write flag and write data unchanged, and no configuration request is made.
- R6: An access to the address-port dword with fewer than four byte enables is forwarded on the I/O interface and leaves the selector register unchanged.
- R7: An access to any other port address is forwarded on the I/O interface.
- R8: A configuration read whose completion has `cfg_cpl_ok` = 0 returns FFh on every enabled byte lane.
- R9: At most one access is in flight. `hst_rdy` is low from the cycle after acceptance through the response cycle. `hst_rsp_vld` is a one-cycle pulse, raised in the cycle after the completion is seen, or in the cycle after acceptance for a selector register access.
- R10: A downstream request is raised in the cycle after host acceptance. It stays raised with stable fields until the cycle in which its ready is sampled high, and drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| hst_vld | input | 1 | Host access valid |
| hst_wr | input | 1 | Host access is a write |
| hst_dw_addr | input | PORT_AW-2 | Host dword port address |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data on native lanes |
| hst_rdy | output | 1 | Block idle and able to accept |
| hst_rsp_vld | output | 1 | One-cycle response pulse |
| hst_rdata | output | 32 | Response read data |
| cfg_req_vld | output | 1 | Configuration request valid |
| cfg_req_rdy | input | 1 | Configuration request taken |
| cfg_wr | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_dw | output | 6 | Dword index within the 256-byte space |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_cpl_vld | input | 1 | Configuration completion |
| cfg_cpl_ok | input | 1 | Completion successful (0: unsupported or absent) |
| cfg_cpl_data | input | 32 | Completion read data |
| io_req_vld | output | 1 | Forwarded I/O request valid |
| io_req_rdy | input | 1 | Forwarded request taken |
| io_wr | output | 1 | Forwarded write |
| io_dw_addr | output | PORT_AW-2 | Forwarded dword address |
| io_be | output | 4 | Forwarded byte enables |
| io_wdata | output | 32 | Forwarded write data |
| io_cpl_vld | input | 1 | I/O completion |
| io_cpl_data | input | 32 | I/O completion read data |

## Verification
The host is accepted on the edge where `hst_vld` meets `hst_rdy`, so the bench expects the selector register response one edge later. For the other paths it expects the downstream request one edge later. The request must still be raised one cycle on with ready held low. It must be gone one edge after ready is given. The response pulse must appear one edge after the completion, and `hst_rdy` must be high again one edge after that. Every such check samples at the falling edge that follows the registering edge. Alongside this, a behavioural busy model updated on each rising edge is compared against `hst_rdy` and the request and response strobes at every falling edge.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  // Selector register contents, field widths fixed by the port format.
  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_sel_t;

  localparam int SEL_FIELD_W = $bits(cfg_sel_t) - 1;

  typedef enum logic [1:0] {
    PATH_LOCAL = 2'd0,
    PATH_CFG   = 2'd1,
    PATH_IO    = 2'd2
  } path_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CREQ  = 3'd1,
    ST_CWAIT = 3'd2,
    ST_IREQ  = 3'd3,
    ST_IWAIT = 3'd4,
    ST_RESP  = 3'd5
  } ctl_state_e;
endpackage

// File: rtl/cpx_sel_reg.sv
module cpx_sel_reg
  import cpx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_en_bit,
  input  logic [SEL_FIELD_W-1:0] wr_fields,
  output cfg_sel_t               sel_q,
  output logic [DATA_W-1:0]      rd_view
);
  cfg_sel_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) begin
      sel_d.en                = wr_en_bit;
      {sel_d.bus, sel_d.dev,
       sel_d.fn,  sel_d.dw}   = wr_fields;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_en) sel_q <= sel_d;
  end

  // Reserved bits and the two low offset bits always read as zero.
  assign rd_view = {sel_q.en, 7'b0, sel_q.bus, sel_q.dev, sel_q.fn, sel_q.dw, 2'b00};
endmodule

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
#(
  parameter int          PORT_AW   = 16,
  parameter int unsigned ADDR_PORT = 32'hCF8,
  parameter int unsigned DATA_PORT = 32'hCFC,
  localparam int         DW_AW     = PORT_AW - 2
) (
  input  logic [DW_AW-1:0] dw_addr,
  input  logic [LANES-1:0] be,
  input  logic             cfg_en,
  output path_e            path
);
  localparam logic [DW_AW-1:0] ADDR_DW = DW_AW'(ADDR_PORT >> 2);
  localparam logic [DW_AW-1:0] DATA_DW = DW_AW'(DATA_PORT >> 2);

  logic hit_addr, hit_data, full_dw;

  always_comb begin
    hit_addr = (dw_addr == ADDR_DW);
    hit_data = (dw_addr == DATA_DW);
    full_dw  = &be;
    if (hit_addr && full_dw)      path = PATH_LOCAL;
    else if (hit_data && cfg_en)  path = PATH_CFG;
    else                          path = PATH_IO;
  end
endmodule

// File: rtl/cpx_lane_shape.sv
module cpx_lane_shape
  import cpx_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] dst
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dst[8*i +: 8] = be[i] ? src[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
  import cpx_pkg::*;
#(
  parameter  int PORT_AW = 16,
  localparam int DW_AW   = PORT_AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_vld,
  input  logic              hst_wr,
  input  logic [DW_AW-1:0]  hst_dw_addr,
  input  logic [LANES-1:0]  hst_be,
  input  logic [DATA_W-1:0] hst_wdata,
  input  path_e             path_i,
  input  logic [DATA_W-1:0] reg_view_i,
  output logic              hst_rdy,
  output logic              hst_rsp_vld,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              reg_wr_en,
  output logic              cfg_req_vld,
  input  logic              cfg_req_rdy,
  input  logic              cfg_cpl_vld,
  input  logic              cfg_cpl_ok,
  input  logic [DATA_W-1:0] cfg_cpl_data,
  output logic              io_req_vld,
  input  logic              io_req_rdy,
  input  logic              io_cpl_vld,
  input  logic [DATA_W-1:0] io_cpl_data,
  output logic              req_wr,
  output logic [DW_AW-1:0]  req_dw_addr,
  output logic [LANES-1:0]  req_be,
  output logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] shp_src,
  output logic [LANES-1:0]  shp_be,
  input  logic [DATA_W-1:0] shp_out
);
  ctl_state_e        state_q, state_d;
  logic              accept;
  logic              rdata_en;
  logic              wr_q;
  logic [DW_AW-1:0]  dwa_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  assign accept = (state_q == ST_IDLE) && hst_vld;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (hst_vld) begin
        unique case (path_i)
          PATH_LOCAL: state_d = ST_RESP;
          PATH_CFG:   state_d = ST_CREQ;
          default:    state_d = ST_IREQ;
        endcase
      end
      ST_CREQ:  if (cfg_req_rdy) state_d = ST_CWAIT;
      ST_CWAIT: if (cfg_cpl_vld) state_d = ST_RESP;
      ST_IREQ:  if (io_req_rdy)  state_d = ST_IWAIT;
      ST_IWAIT: if (io_cpl_vld)  state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Response data source and lane selection
  always_comb begin
    shp_be = (state_q == ST_IDLE) ? hst_be : be_q;
    unique case (state_q)
      ST_IDLE:  shp_src = reg_view_i;
      ST_CWAIT: shp_src = cfg_cpl_ok ? cfg_cpl_data : '1;
      ST_IWAIT: shp_src = io_cpl_data;
      default:  shp_src = '0;
    endcase
    rdata_en = (accept && (path_i == PATH_LOCAL))
             || ((state_q == ST_CWAIT) && cfg_cpl_vld)
             || ((state_q == ST_IWAIT) && io_cpl_vld);
    reg_wr_en = accept && (path_i == PATH_LOCAL) && hst_wr;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      dwa_q   <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= hst_wr;
      dwa_q   <= hst_dw_addr;
      be_q    <= hst_be;
      wdata_q <= hst_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= shp_out;
  end

  assign hst_rdy     = (state_q == ST_IDLE);
  assign hst_rsp_vld = (state_q == ST_RESP);
  assign hst_rdata   = rdata_q;
  assign cfg_req_vld = (state_q == ST_CREQ);
  assign io_req_vld  = (state_q == ST_IREQ);
  assign req_wr      = wr_q;
  assign req_dw_addr = dwa_q;
  assign req_be      = be_q;
  assign req_wdata   = wdata_q;
endmodule

// File: rtl/cfg_port_xlat.sv
module cfg_port_xlat
  import cpx_pkg::*;
#(
  parameter  int          PORT_AW   = 16,
  parameter  int unsigned ADDR_PORT = 32'hCF8,
  parameter  int unsigned DATA_PORT = 32'hCFC,
  localparam int          DW_AW     = PORT_AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_vld,
  input  logic              hst_wr,
  input  logic [DW_AW-1:0]  hst_dw_addr,
  input  logic [3:0]        hst_be,
  input  logic [31:0]       hst_wdata,
  output logic              hst_rdy,
  output logic              hst_rsp_vld,
  output logic [31:0]       hst_rdata,
  output logic              cfg_req_vld,
  input  logic              cfg_req_rdy,
  output logic              cfg_wr,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [5:0]        cfg_dw,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_cpl_vld,
  input  logic              cfg_cpl_ok,
  input  logic [31:0]       cfg_cpl_data,
  output logic              io_req_vld,
  input  logic              io_req_rdy,
  output logic              io_wr,
  output logic [DW_AW-1:0]  io_dw_addr,
  output logic [3:0]        io_be,
  output logic [31:0]       io_wdata,
  input  logic              io_cpl_vld,
  input  logic [31:0]       io_cpl_data
);
  cfg_sel_t          sel;
  logic [DATA_W-1:0] reg_view;
  logic              reg_wr_en;
  path_e             path;
  logic              req_wr;
  logic [DW_AW-1:0]  req_dw_addr;
  logic [LANES-1:0]  req_be;
  logic [DATA_W-1:0] req_wdata;
  logic [DATA_W-1:0] shp_src, shp_out;
  logic [LANES-1:0]  shp_be;

  cpx_sel_reg u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_en_bit (hst_wdata[31]),
    .wr_fields (hst_wdata[23:2]),
    .sel_q     (sel),
    .rd_view   (reg_view)
  );

  cpx_decode #(
    .PORT_AW   (PORT_AW),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_dec (
    .dw_addr (hst_dw_addr),
    .be      (hst_be),
    .cfg_en  (sel.en),
    .path    (path)
  );

  cpx_lane_shape u_shape (
    .src (shp_src),
    .be  (shp_be),
    .dst (shp_out)
  );

  cpx_ctrl #(.PORT_AW(PORT_AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .hst_vld      (hst_vld),
    .hst_wr       (hst_wr),
    .hst_dw_addr  (hst_dw_addr),
    .hst_be       (hst_be),
    .hst_wdata    (hst_wdata),
    .path_i       (path),
    .reg_view_i   (reg_view),
    .hst_rdy      (hst_rdy),
    .hst_rsp_vld  (hst_rsp_vld),
    .hst_rdata    (hst_rdata),
    .reg_wr_en    (reg_wr_en),
    .cfg_req_vld  (cfg_req_vld),
    .cfg_req_rdy  (cfg_req_rdy),
    .cfg_cpl_vld  (cfg_cpl_vld),
    .cfg_cpl_ok   (cfg_cpl_ok),
    .cfg_cpl_data (cfg_cpl_data),
    .io_req_vld   (io_req_vld),
    .io_req_rdy   (io_req_rdy),
    .io_cpl_vld   (io_cpl_vld),
    .io_cpl_data  (io_cpl_data),
    .req_wr       (req_wr),
    .req_dw_addr  (req_dw_addr),
    .req_be       (req_be),
    .req_wdata    (req_wdata),
    .shp_src      (shp_src),
    .shp_be       (shp_be),
    .shp_out      (shp_out)
  );

  // The selector cannot change while a request is in flight, so the
  // configuration target is driven straight from the register.
  assign cfg_wr     = req_wr;
  assign cfg_bus    = sel.bus;
  assign cfg_dev    = sel.dev;
  assign cfg_fn     = sel.fn;
  assign cfg_dw     = sel.dw;
  assign cfg_be     = req_be;
  assign cfg_wdata  = req_wdata;
  assign io_wr      = req_wr;
  assign io_dw_addr = req_dw_addr;
  assign io_be      = req_be;
  assign io_wdata   = req_wdata;
endmodule

// File: rtl/cpx_checker.sv
module cpx_checker #(
  parameter  int PORT_AW = 16,
  localparam int DW_AW   = PORT_AW - 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_vld,
  input logic [3:0]       hst_be,
  input logic             hst_rdy,
  input logic             hst_rsp_vld,
  input logic [31:0]      hst_rdata,
  input logic             cfg_req_vld,
  input logic             cfg_req_rdy,
  input logic [7:0]       cfg_bus,
  input logic [3:0]       cfg_be,
  input logic [31:0]      cfg_wdata,
  input logic             io_req_vld,
  input logic             io_req_rdy,
  input logic [DW_AW-1:0] io_dw_addr,
  input logic [3:0]       io_be
);
  logic [3:0]  be_seen;
  logic [31:0] off_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  be_seen <= '0;
    else if (hst_vld && hst_rdy) be_seen <= hst_be;
  end

  always_comb begin
    for (int i = 0; i < 4; i++) off_lanes[8*i +: 8] = be_seen[i] ? 8'h00 : 8'hFF;
  end

  assert_one_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req_vld && io_req_vld));

  assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rsp_vld |-> ((hst_rdata & off_lanes) == 32'h0));

  assert_rdy_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_vld || io_req_vld || hst_rsp_vld) |-> !hst_rdy);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rsp_vld |=> !hst_rsp_vld);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_vld && !cfg_req_rdy) |=>
      (cfg_req_vld && $stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_bus)));

  assert_io_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_vld && !io_req_rdy) |=>
      (io_req_vld && $stable(io_dw_addr) && $stable(io_be)));

  assert_cfg_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_vld && cfg_req_rdy) |=> !cfg_req_vld);
endmodule

bind cfg_port_xlat cpx_checker #(.PORT_AW(PORT_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hst_vld     (hst_vld),
  .hst_be      (hst_be),
  .hst_rdy     (hst_rdy),
  .hst_rsp_vld (hst_rsp_vld),
  .hst_rdata   (hst_rdata),
  .cfg_req_vld (cfg_req_vld),
  .cfg_req_rdy (cfg_req_rdy),
  .cfg_bus     (cfg_bus),
  .cfg_be      (cfg_be),
  .cfg_wdata   (cfg_wdata),
  .io_req_vld  (io_req_vld),
  .io_req_rdy  (io_req_rdy),
  .io_dw_addr  (io_dw_addr),
  .io_be       (io_be)
);

// File: tb/cfg_port_xlat_tb.sv
module cfg_port_xlat_tb;
  localparam logic [13:0] A_DW = 14'h33E;  // address port dword
  localparam logic [13:0] D_DW = 14'h33F;  // data window dword

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        hst_vld = 0, hst_wr = 0;
  logic [13:0] hst_dw_addr = '0;
  logic [3:0]  hst_be = '0;
  logic [31:0] hst_wdata = '0;
  logic        hst_rdy, hst_rsp_vld;
  logic [31:0] hst_rdata;
  logic        cfg_req_vld, cfg_req_rdy = 0, cfg_wr;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_dw;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_cpl_vld = 0, cfg_cpl_ok = 0;
  logic [31:0] cfg_cpl_data = '0;
  logic        io_req_vld, io_req_rdy = 0, io_wr;
  logic [13:0] io_dw_addr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic        io_cpl_vld = 0;
  logic [31:0] io_cpl_data = '0;

  cfg_port_xlat u_dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] m_reg = '0;   // bench's own view of the selector
  bit m_busy = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be, input logic [31:0] d);
    for (int i = 0; i < 4; i++) if (!be[i]) d[8*i +: 8] = 8'h00;
    return d;
  endfunction

  // Behavioural busy model, compared on every clock (R9)
  always @(posedge clk) begin
    if (!rst_n)                     m_busy <= 0;
    else if (!m_busy && hst_vld)    m_busy <= 1;
    else if (m_busy && hst_rsp_vld) m_busy <= 0;
  end
  always @(negedge clk) if (rst_n) begin
    chk(hst_rdy == !m_busy, "R9 rdy vs busy model", 32'(hst_rdy), 32'(!m_busy));
    if (!m_busy) chk(!(hst_rsp_vld || cfg_req_vld || io_req_vld), "R9 strobe while idle",
                     {29'b0, hst_rsp_vld, cfg_req_vld, io_req_vld}, 32'h0);
  end

  // path: 0 selector register, 1 configuration, 2 forwarded I/O
  task automatic xact(input logic wr, input logic [13:0] dwa, input logic [3:0] be,
                      input logic [31:0] wd, input int path, input logic ok,
                      input logic [31:0] src, input bit chk_rd, input logic [31:0] exp_rd,
                      input string tag);
    @(negedge clk);
    hst_vld = 1; hst_wr = wr; hst_dw_addr = dwa; hst_be = be; hst_wdata = wd;
    @(negedge clk);
    hst_vld = 0;
    if (path == 0) begin
      chk(hst_rsp_vld === 1'b1, {tag, " local rsp timing"}, 32'(hst_rsp_vld), 32'h1);
      if (chk_rd) chk(hst_rdata === exp_rd, {tag, " local rdata"}, hst_rdata, exp_rd);
      chk(!cfg_req_vld && !io_req_vld, {tag, " local no downstream"},
          {30'b0, cfg_req_vld, io_req_vld}, 32'h0);
    end else begin
      if (path == 1) begin
        chk(cfg_req_vld && !io_req_vld, {tag, " cfg req R10"}, {30'b0, cfg_req_vld, io_req_vld}, 32'h2);
        chk({cfg_bus, cfg_dev, cfg_fn, cfg_dw} === m_reg[23:2], {tag, " cfg target R3"},
            32'({cfg_bus, cfg_dev, cfg_fn, cfg_dw}), 32'(m_reg[23:2]));
        chk(cfg_be === be && cfg_wr === wr && cfg_wdata === wd, {tag, " cfg be/wr/data R4"},
            cfg_wdata, wd);
      end else begin
        chk(io_req_vld && !cfg_req_vld, {tag, " io req R10"}, {30'b0, cfg_req_vld, io_req_vld}, 32'h1);
        chk(io_dw_addr === dwa && io_be === be && io_wr === wr && io_wdata === wd,
            {tag, " io fields"}, 32'({io_dw_addr, io_be}), 32'({dwa, be}));
      end
      @(negedge clk);
      chk((path == 1) ? cfg_req_vld : io_req_vld, {tag, " req held R10"}, 32'h0, 32'h1);
      if (path == 1) cfg_req_rdy = 1; else io_req_rdy = 1;
      @(negedge clk);
      cfg_req_rdy = 0; io_req_rdy = 0;
      chk(!cfg_req_vld && !io_req_vld && !hst_rdy, {tag, " req dropped R10"},
          {29'b0, cfg_req_vld, io_req_vld, hst_rdy}, 32'h0);
      if (path == 1) begin cfg_cpl_vld = 1; cfg_cpl_ok = ok; cfg_cpl_data = src; end
      else begin io_cpl_vld = 1; io_cpl_data = src; end
      @(negedge clk);
      cfg_cpl_vld = 0; io_cpl_vld = 0;
      chk(hst_rsp_vld === 1'b1, {tag, " rsp timing R9"}, 32'(hst_rsp_vld), 32'h1);
      if (chk_rd) chk(hst_rdata === exp_rd, {tag, " rdata"}, hst_rdata, exp_rd);
    end
    @(negedge clk);
    chk(hst_rdy === 1'b1 && !hst_rsp_vld, {tag, " back idle R9"}, 32'(hst_rdy), 32'h1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hst_rdy && !cfg_req_vld && !io_req_vld, "R1 reset outputs",
        {29'b0, hst_rdy, cfg_req_vld, io_req_vld}, 32'h4);
    xact(0, A_DW, 4'hF, 0, 0, 1, 0, 1, 32'h0, "R1 reset readback");

    // R2: reserved and low bits written as ones must read as zero
    xact(1, A_DW, 4'hF, 32'hFFAB_FAFF, 0, 1, 0, 0, 0, "R2 write");
    m_reg = 32'h80AB_FAFC;
    xact(0, A_DW, 4'hF, 0, 0, 1, 0, 1, 32'h80AB_FAFC, "R2 readback");

    // R3: full-dword configuration read
    xact(0, D_DW, 4'hF, 0, 1, 1, 32'h1234_5678, 1, 32'h1234_5678, "R3 cfg read");
    // R4: byte write and upper word read on the data window
    xact(1, D_DW, 4'b0100, 32'h0077_0000, 1, 1, 0, 0, 0, "R4 byte write");
    xact(0, D_DW, 4'b1100, 0, 1, 1, 32'hAABB_CCDD, 1, lanes(4'b1100, 32'hAABB_CCDD), "R4 word read");
    // R8: unsupported completion returns ones on enabled lanes
    xact(0, D_DW, 4'hF, 0, 1, 0, 32'h0BAD_0BAD, 1, 32'hFFFF_FFFF, "R8 dword");
    xact(0, D_DW, 4'b0011, 0, 1, 0, 32'h0BAD_0BAD, 1, 32'h0000_FFFF, "R8 word");

    // R6: narrow access to the address port goes out as I/O, selector unchanged
    xact(1, A_DW, 4'b0001, 32'h0000_0055, 2, 1, 0, 0, 0, "R6 narrow write");
    xact(0, A_DW, 4'b0010, 0, 2, 1, 32'h1111_2222, 1, 32'h0000_2200, "R6 narrow read");
    xact(0, A_DW, 4'hF, 0, 0, 1, 0, 1, 32'h80AB_FAFC, "R6 selector kept");

    // R5: enable cleared, data window forwarded unchanged
    xact(1, A_DW, 4'hF, 32'h0000_1234, 0, 1, 0, 0, 0, "R5 disable");
    m_reg = 32'h0000_1234;
    xact(0, A_DW, 4'hF, 0, 0, 1, 0, 1, 32'h0000_1234, "R5 readback");
    xact(0, D_DW, 4'b1000, 0, 2, 1, 32'hCAFE_F00D, 1, 32'hCA00_0000, "R5 forwarded read");
    xact(1, D_DW, 4'hF, 32'hDEAD_BEEF, 2, 1, 0, 0, 0, "R5 forwarded write");

    // R7: unrelated port
    xact(1, 14'h0020, 4'b0001, 32'h0000_00A5, 2, 1, 0, 0, 0, "R7 other write");
    xact(0, 14'h0020, 4'hF, 0, 2, 1, 32'h5A5A_0F0F, 1, 32'h5A5A_0F0F, "R7 other read");

    // Re-enable with new selector and check a second configuration target (R3)
    xact(1, A_DW, 4'hF, 32'h8001_0B40, 0, 1, 0, 0, 0, "R3 reselect");
    m_reg = 32'h8001_0B40;
    xact(1, D_DW, 4'b0011, 32'h0000_BEEF, 1, 1, 0, 0, 0, "R3 cfg write");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule